// File: doc/BRIEF.md
# SPI Master with Address-Selected Chip Select Handling

This block is an SPI master that sits on a small 16-bit host bus with eight word offsets. Each data access runs one 16-bit full-duplex transfer, MSB first, on one of four active-low chip selects. A control word sets the speed code, the clock idle level and which chip select to use. The speed code runs the serial clock either at the system clock rate or at the system clock divided by twice the code.

Software never drives chip select directly. The offset it writes decides whether chip select stays low after the transfer, so that more words can follow in the same transaction, or goes high once the last bit is done. Reading the streaming-read offset returns the word from the last transfer and starts the next 16-bit read at once. MOSI is held at zero for that read, so a burst of reads keeps the shifter busy between host accesses. A data access that arrives while the shifter is running holds the bus ready signal low until the shifter is free.

Top module: `spi_auto_cs`

## Requirements
- R1: After reset all four chip selects are high, the serial clock is low, ready is high and the received-word register (offset 1) reads 0.
- R2: The control word at offset 0 holds bit 14 = clock idle level, bits 13..10 = speed code and bits 9..8 = chip select index. It reads back bit 15 as the live MISO pin and bits 7..0 as zero.
- R3: A transfer lasts 16 system cycles for speed code 0 and 32·n cycles for code n ≥ 1, which gives a serial clock period of 2·n cycles.
- R4: Each transfer shifts the written word out on MOSI MSB first. It captures MISO on the leading clock edge, and the captured word then reads back at offset 1.
- R5: Writing offset 4 starts a transfer, and chip select stays low when that transfer ends.
- R6: Writing offset 6 starts a transfer, and all chip selects go high when its last bit ends.
- R7: At most one chip select is low at any time. The chip select is the one named by the index at the moment a transaction opens. A change to the index while chip select is low has no effect until the transaction closes.
- R8: While idle, the serial clock rests at bit 14 for speed codes 1..15 and low for code 0. A new level written while a chip select is low is applied only after the transaction closes.
- R9: Reading offset 5 returns the last received word and starts another 16-bit transfer with MOSI all zeros, keeping chip select low.
- R10: Offsets 2, 3 and 7 read as zero, and writes to them change no output and no register.
- R11: An access to offsets 1, 4, 5 or 6 while a transfer runs holds ready low until the transfer ends. An access to offset 0 is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Word offset of the host access |
| bus_rd | input | 1 | Host read request |
| bus_wr | input | 1 | Host write request |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, valid while ready is high |
| bus_ready | output | 1 | Access completes on the clock edge where this is high |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
Assertions check on every cycle that the chip select vector is one-hot-low or all high, and that it cannot move while the shifter runs. They also check that the release and keep decisions take effect on the cycle after the last bit, that the half-period counter stays inside its limit, that no transfer is started while one is running, and that the clock rests without moving between transfers inside an open transaction. Only the bench's scenarios can show the data path end to end: the MOSI words seen by a slave model, the MISO words read back, the exact stall lengths for each speed code, the streaming-read word order, and the rule that a control change made mid-transaction is ignored.

// File: rtl/spi_auto_pkg.sv
package spi_auto_pkg;

  typedef enum logic [2:0] {
    OFS_CTRL = 3'd0,
    OFS_RXD  = 3'd1,
    OFS_RSV2 = 3'd2,
    OFS_RSV3 = 3'd3,
    OFS_HOLD = 3'd4,
    OFS_PIPE = 3'd5,
    OFS_DROP = 3'd6,
    OFS_RSV7 = 3'd7
  } spi_ofs_e;

  // speed code 0 runs one bit per system cycle
  function automatic logic is_fast(input int code);
    return code == 0;
  endfunction

  // last count value of one serial clock half period for code >= 1
  function automatic int half_lim(input int code);
    return (code == 0) ? 0 : code - 1;
  endfunction

  // system cycles one transfer of nbits occupies
  function automatic int xfer_cycles(input int code, input int nbits);
    return (code == 0) ? nbits : 2 * code * nbits;
  endfunction

endpackage

// File: rtl/spi_auto_host.sv
module spi_auto_host
  import spi_auto_pkg::*;
#(
  parameter int DW  = 16,
  parameter int SPW = 4,
  parameter int NCS = 4,
  localparam int LW = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     addr,
  input  logic           rd,
  input  logic           wr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           ready,
  input  logic           miso,
  input  logic           busy,
  input  logic [DW-1:0]  rx_word,
  output logic           ctl_cpol,
  output logic [SPW-1:0] ctl_spd,
  output logic [LW-1:0]  ctl_lun,
  output logic           start,
  output logic [DW-1:0]  start_tx,
  output logic           start_rel
);

  localparam int P_MISO = DW - 1;
  localparam int P_CPOL = DW - 2;
  localparam int P_SPLO = P_CPOL - SPW;
  localparam int P_LNLO = P_SPLO - LW;

  spi_ofs_e ofs;
  assign ofs = spi_ofs_e'(addr);

  logic req, data_acc, go;
  assign req      = rd | wr;
  assign data_acc = req & (ofs == OFS_RXD || ofs == OFS_HOLD ||
                           ofs == OFS_PIPE || ofs == OFS_DROP);
  assign ready    = !(data_acc && busy);
  assign go       = req & ready;

  assign start     = go & ((wr & (ofs == OFS_HOLD || ofs == OFS_DROP)) |
                           (rd & !wr & (ofs == OFS_PIPE)));
  assign start_tx  = wr ? wdata : '0;
  assign start_rel = wr & (ofs == OFS_DROP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_cpol <= 1'b0;
      ctl_spd  <= '0;
      ctl_lun  <= '0;
    end else if (go && wr && ofs == OFS_CTRL) begin
      ctl_cpol <= wdata[P_CPOL];
      ctl_spd  <= wdata[P_CPOL-1:P_SPLO];
      ctl_lun  <= wdata[P_SPLO-1:P_LNLO];
    end
  end

  wire unused_ctl_bits = &{1'b0, wdata[P_MISO], wdata[P_LNLO-1:0]};

  logic [DW-1:0] ctl_view;
  always_comb begin
    ctl_view                    = '0;
    ctl_view[P_MISO]            = miso;
    ctl_view[P_CPOL]            = ctl_cpol;
    ctl_view[P_CPOL-1:P_SPLO]   = ctl_spd;
    ctl_view[P_SPLO-1:P_LNLO]   = ctl_lun;
  end

  always_comb begin
    unique case (ofs)
      OFS_CTRL:                              rdata = ctl_view;
      OFS_RXD, OFS_HOLD, OFS_PIPE, OFS_DROP: rdata = rx_word;
      default:                               rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_auto_shift.sv
module spi_auto_shift
  import spi_auto_pkg::*;
#(
  parameter int DW  = 16,
  parameter int SPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [DW-1:0]  tx_word,
  input  logic [SPW-1:0] speed,
  input  logic           cpol,
  input  logic           miso,
  output logic           busy,
  output logic           fin,
  output logic [DW-1:0]  rx_word,
  output logic           sclk,
  output logic           mosi
);

  localparam int BCW = $clog2(DW);
  localparam logic [BCW-1:0] LAST = BCW'(DW - 1);

  logic           busy_q, ph_q;
  logic [SPW-1:0] cnt_q, spd_q;
  logic [BCW-1:0] bit_q;
  logic [DW-1:0]  tx_q, rx_sh, rx_q;

  // named events for the checks below
  logic           fast, half_end, bit_end, samp;
  logic [SPW-1:0] hlim;
  logic [DW-1:0]  rx_next;

  assign fast     = is_fast(int'(spd_q));
  assign hlim     = SPW'(half_lim(int'(spd_q)));
  assign half_end = busy_q & !fast & (cnt_q == hlim);
  assign bit_end  = busy_q & (fast | (half_end & ph_q));
  assign samp     = busy_q & (fast | (half_end & !ph_q));
  assign fin      = bit_end & (bit_q == LAST);
  assign rx_next  = {rx_sh[DW-2:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      spd_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      spd_q  <= speed;
      bit_q  <= '0;
      tx_q   <= tx_word;
    end else if (busy_q) begin
      cnt_q <= (half_end || fast) ? '0 : cnt_q + 1'b1;
      if (half_end) ph_q <= ~ph_q;
      if (samp) rx_sh <= rx_next;
      if (bit_end) begin
        tx_q  <= {tx_q[DW-2:0], 1'b0};
        bit_q <= bit_q + 1'b1;
      end
      if (fin) begin
        busy_q <= 1'b0;
        rx_q   <= fast ? rx_next : rx_sh;
      end
    end
  end

  assign busy    = busy_q;
  assign rx_word = rx_q;
  assign mosi    = busy_q & tx_q[DW-1];
  assign sclk    = busy_q ? (fast ? ~clk : (ph_q ^ cpol)) : cpol;

  a_r3_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fast) |-> (cnt_q <= hlim));

  a_r11_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

endmodule

// File: rtl/spi_auto_csel.sv
module spi_auto_csel #(
  parameter int SPW = 4,
  parameter int NCS = 4,
  localparam int LW = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           start_rel,
  input  logic           fin,
  input  logic [LW-1:0]  lun,
  input  logic           ctl_cpol,
  input  logic [SPW-1:0] ctl_spd,
  output logic [NCS-1:0] cs_n,
  output logic           cpol_eff,
  output logic           open
);

  logic [NCS-1:0] pat_n, cs_q;
  logic           rel_q, cpol_q;

  for (genvar i = 0; i < NCS; i++) begin : g_sel
    assign pat_n[i] = (lun != LW'(i));
  end

  assign open     = (cs_q != '1);
  assign cpol_eff = open ? cpol_q : (ctl_cpol & (ctl_spd != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '1;
      rel_q  <= 1'b0;
      cpol_q <= 1'b0;
    end else begin
      cpol_q <= cpol_eff;
      if (start) begin
        rel_q <= start_rel;
        if (!open) cs_q <= pat_n;
      end
      if (fin && rel_q) cs_q <= '1;
    end
  end

  assign cs_n = cs_q;

  a_r7_cs_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_q));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && rel_q) |=> (cs_q == '1));

  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !rel_q) |=> (cs_q != '1));

endmodule

// File: rtl/spi_auto_cs.sv
module spi_auto_cs
  import spi_auto_pkg::*;
#(
  parameter int DW  = 16,
  parameter int SPW = 4,
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     bus_addr,
  input  logic           bus_rd,
  input  logic           bus_wr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_ready,
  output logic           spi_sclk,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs_n
);

  localparam int LW = $clog2(NCS);

  logic           busy, fin, start, start_rel, ctl_cpol, cpol_eff, open;
  logic [SPW-1:0] ctl_spd;
  logic [LW-1:0]  ctl_lun;
  logic [DW-1:0]  rx_word, start_tx;

  spi_auto_host #(.DW(DW), .SPW(SPW), .NCS(NCS)) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .rd        (bus_rd),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .ready     (bus_ready),
    .miso      (spi_miso),
    .busy      (busy),
    .rx_word   (rx_word),
    .ctl_cpol  (ctl_cpol),
    .ctl_spd   (ctl_spd),
    .ctl_lun   (ctl_lun),
    .start     (start),
    .start_tx  (start_tx),
    .start_rel (start_rel)
  );

  spi_auto_shift #(.DW(DW), .SPW(SPW)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_word (start_tx),
    .speed   (ctl_spd),
    .cpol    (cpol_eff),
    .miso    (spi_miso),
    .busy    (busy),
    .fin     (fin),
    .rx_word (rx_word),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi)
  );

  spi_auto_csel #(.SPW(SPW), .NCS(NCS)) u_csel (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_rel (start_rel),
    .fin       (fin),
    .lun       (ctl_lun),
    .ctl_cpol  (ctl_cpol),
    .ctl_spd   (ctl_spd),
    .cs_n      (spi_cs_n),
    .cpol_eff  (cpol_eff),
    .open      (open)
  );

  a_r7_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(spi_cs_n));

  a_r8_sclk_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && open && $past(open)) |-> $stable(spi_sclk));

endmodule

// File: tb/sim_spi_auto_cs.sv
module sim_spi_auto_cs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  b_addr = '0;
  logic        b_rd = 1'b0, b_wr = 1'b0;
  logic [15:0] b_wdata = '0;
  logic [15:0] b_rdata;
  logic        b_ready;
  logic        spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [3:0]  spi_cs_n;

  always #5 clk = ~clk;

  spi_auto_cs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_rd(b_rd), .bus_wr(b_wr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .bus_ready(b_ready),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int n_cmp = 0, n_bad = 0;
  bit run_done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_stall(input int code);
    return (code == 0) ? 16 : code * 32;
  endfunction

  function automatic logic [15:0] ctl(input int cpol, input int spd, input int lun);
    return 16'((cpol << 14) | (spd << 10) | (lun << 8));
  endfunction

  // slave model and MOSI scoreboard
  logic [15:0] sl_word = '0, cap = '0;
  int          idx = 0;
  logic        idle_lvl = 1'b0;
  logic [15:0] exp_mosi[$];

  always @(spi_sclk) begin
    if (spi_cs_n != 4'hF) begin
      if (spi_sclk != idle_lvl) begin
        cap = {cap[14:0], spi_mosi};
        idx++;
        if (idx == 16) begin
          idx = 0;
          if (exp_mosi.size() == 0) check("R4 unexpected MOSI word", cap, 32'hDEAD);
          else check("R4 MOSI word MSB first", cap, exp_mosi.pop_front());
        end
      end else if (idx != 0) begin
        spi_miso <= #1 sl_word[15-idx];
      end
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d, output int st);
    st = 0; b_addr = a; b_wdata = d; b_wr = 1'b1;
    #1;
    while (!b_ready) begin st++; @(negedge clk); end
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d, output int st);
    st = 0; b_addr = a; b_rd = 1'b1;
    #1;
    while (!b_ready) begin st++; @(negedge clk); end
    d = b_rdata;
    @(negedge clk);
    b_rd = 1'b0;
  endtask

  task automatic arm_slave(input logic [15:0] sl, input logic [15:0] tx);
    sl_word = sl; spi_miso = sl[15]; idx = 0; cap = '0;
    exp_mosi.push_back(tx);
  endtask

  task automatic send(input logic [2:0] a, input logic [15:0] tx, input logic [15:0] sl);
    int st;
    arm_slave(sl, tx);
    bus_wr(a, tx, st);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!run_done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int st;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 cs idle", spi_cs_n, 4'hF);
    check("R1 sclk low", spi_sclk, 1'b0);
    check("R1 ready", b_ready, 1'b1);
    bus_rd(3'd1, d, st);
    check("R1 rx reset", d, 16'h0000);
    spi_miso = 1'b1;
    bus_rd(3'd0, d, st);
    check("R2 miso bit", d, 16'h8000);
    spi_miso = 1'b0;

    // speed 2, lun 1, low byte written as ones
    bus_wr(3'd0, ctl(0, 2, 1) | 16'h00FF, st);
    bus_rd(3'd0, d, st);
    check("R2 control fields", d, ctl(0, 2, 1));

    send(3'd4, 16'hA5C3, 16'h3C5A);
    bus_rd(3'd1, d, st);
    check("R3 stall speed 2", st, exp_stall(2));
    check("R4 rx word", d, 16'h3C5A);
    check("R5 cs kept low", spi_cs_n, 4'b1101);

    // index change while open must not move chip select
    bus_wr(3'd0, ctl(0, 2, 2), st);
    send(3'd6, 16'h0F0F, 16'h8001);
    bus_rd(3'd0, d, st);
    check("R11 control not stalled", st, 0);
    repeat (5) @(negedge clk);
    check("R7 cs held mid transaction", spi_cs_n, 4'b1101);
    bus_rd(3'd1, d, st);
    check("R4 rx word 2", d, 16'h8001);
    check("R6 cs released", spi_cs_n, 4'hF);

    // speed 0 with idle level bit set: level ignored
    bus_wr(3'd0, ctl(1, 0, 2), st);
    #1;
    check("R8 code 0 rests low", spi_sclk, 1'b0);
    send(3'd6, 16'h1234, 16'hFEDC);
    bus_rd(3'd1, d, st);
    check("R3 stall speed 0", st, exp_stall(0));
    check("R4 rx word fast", d, 16'hFEDC);
    check("R6 cs released fast", spi_cs_n, 4'hF);

    // speed 1, idle high, lun 3
    bus_wr(3'd0, ctl(1, 1, 3), st);
    #1;
    check("R8 idle level high", spi_sclk, 1'b1);
    idle_lvl = 1'b1;
    send(3'd4, 16'hFFFF, 16'h0001);
    bus_rd(3'd1, d, st);
    check("R3 stall speed 1", st, exp_stall(1));
    check("R4 rx word idle high", d, 16'h0001);
    check("R5 cs lun 3 kept", spi_cs_n, 4'b0111);
    bus_wr(3'd0, ctl(0, 1, 3), st);
    #1;
    check("R8 level held while open", spi_sclk, 1'b1);

    // streaming read
    arm_slave(16'hBEEF, 16'h0000);
    bus_rd(3'd5, d, st);
    check("R9 returns last word", d, 16'h0001);
    bus_rd(3'd1, d, st);
    check("R9 next read started", st, exp_stall(1));
    check("R9 streamed word", d, 16'hBEEF);
    check("R9 cs still low", spi_cs_n, 4'b0111);
    send(3'd6, 16'h55AA, 16'h1357);
    bus_rd(3'd1, d, st);
    check("R4 rx word close", d, 16'h1357);
    check("R6 cs released 3", spi_cs_n, 4'hF);
    check("R8 new level after close", spi_sclk, 1'b0);
    idle_lvl = 1'b0;

    // reserved offsets
    spi_miso = 1'b0;
    for (int k = 0; k < 3; k++) begin
      logic [2:0] a;
      a = (k == 0) ? 3'd2 : (k == 1) ? 3'd3 : 3'd7;
      bus_wr(a, 16'hFFFF, st);
      bus_rd(a, d, st);
      check("R10 reserved reads zero", d, 16'h0000);
    end
    bus_rd(3'd0, d, st);
    check("R10 control untouched", d, ctl(0, 1, 3));
    bus_rd(3'd1, d, st);
    check("R10 rx untouched", d, 16'h1357);
    check("R10 cs untouched", spi_cs_n, 4'hF);
    check("R10 sclk untouched", spi_sclk, 1'b0);
    check("R4 scoreboard drained", exp_mosi.size(), 0);

    run_done = 1;
    summary();
    $finish;
  end

endmodule